// File: doc/BRIEF.md
# Preamble Frame Detector and Symbol Timing Locator

This block watches a stream of complex baseband samples for a preamble made of a short pattern that repeats every `LAG` samples. For each accepted sample it updates two running sums over the last `WIN` samples. The first is a lag correlation P, which pairs each sample with the sample `LAG` positions earlier. The second is an energy Q. It then tests their ratio without any divider or square root. Both tests compare a scaled `|P|^2` against a programmable threshold times `Q^2`.

Control has three phases. In the first phase the block searches for a frame. It declares one once `RUN` consecutive samples have passed the detection test. In the second phase it waits for the correlation to collapse, which marks the end of the repeated pattern. The first sample that falls below the second threshold fixes the symbol timing. At that point the block emits a one-cycle strobe together with the zero-based index of that sample. It then stays locked until software clears it with a soft clear.

Top module: `preamble_sync`

## Requirements
- R1: After reset, `frameFound`, `locked` and `syncStrobe` are low and `syncIndex` is 0.
- R2: For sample n, c(m) = x(m-LAG)·conj(x(m)) and e(m) = |x(m)|^2. P(n) is the sum of c(m) and Q(n) is the sum of e(m), both taken over m = n-WIN+1 .. n. Samples before the last reset or clear count as zero. A sample passes detection when 2^FRAC·|P|^2 > thDet·Q^2. It passes the timing test when 2^FRAC·|P|^2 < thSyn·Q^2. Both thresholds are unsigned with FRAC fractional bits.
- R3: While searching, a failing sample sets the run of passing samples back to zero. `frameFound` rises when the run reaches `RUN`. It is visible after the second rising edge that follows the edge on which that sample was accepted.
- R4: Once a frame is found, the sample that completed the run is not tested for timing. The first later sample that passes the timing test raises `locked`. The same sample raises `syncStrobe`, with the same two-edge latency.
- R5: `syncIndex` takes the zero-based count of samples accepted since the last reset or clear, for the sample that caused the lock. It holds that value until the next reset or clear, both of which return it to 0.
- R6: `syncStrobe` is high for exactly one cycle per lock. While locked, further samples change no output.
- R7: When `softClr` is high at an edge, the block returns to search and clears the sample history, the sums, the run and the sample count. A sample offered on that same edge is discarded.
- R8: Cycles with `sampleValid` low change neither the sample history nor any output.
- R9: `frameFound` is high in both the timing phase and the locked phase. `locked` is high only in the locked phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| softClr | input | 1 | Synchronous return to search with cleared history |
| sampleValid | input | 1 | A sample is offered this cycle |
| sampleI | input | W | In-phase part of the sample, signed |
| sampleQ | input | W | Quadrature part of the sample, signed |
| thDet | input | TH_W | Detection threshold, FRAC fractional bits |
| thSyn | input | TH_W | Timing threshold, FRAC fractional bits |
| frameFound | output | 1 | A frame has been detected |
| locked | output | 1 | Symbol timing is fixed |
| syncStrobe | output | 1 | One-cycle pulse at the moment of lock |
| syncIndex | output | CNT_W | Index of the sample that produced the lock |

## Verification
The bench builds the block with 5-bit samples, a lag and window of 4, and a run length of 6. With these values a periodic preamble fills the correlation window within eight samples, and a run resets and restarts within a few dozen. This makes it affordable to sweep a grid of detection and timing thresholds. The grid covers zero, values on both sides of unity, and values just at unity, each against preamble-then-noise traffic. The small widths also keep every term of the reference ratio computation inside plain 64-bit integers.

// File: rtl/psync_pkg.sv
package psync_pkg;

  // Strobes issued by the control towards the datapath
  typedef struct packed {
    logic clearAll;   // wipe history and sums
    logic shiftIn;    // accept the sample on the ports
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_SYNC   = 2'd1,
    ST_LOCK   = 2'd2
  } phase_t;

endpackage

// File: rtl/psync_datapath.sv
module psync_datapath
  import psync_pkg::*;
#(
  parameter int W    = 12,
  parameter int LAG  = 16,
  parameter int WIN  = 16,
  parameter int TH_W = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic signed [W-1:0] sampleI,
  input  logic signed [W-1:0] sampleQ,
  input  logic [TH_W-1:0]     thDet,
  input  logic [TH_W-1:0]     thSyn,
  output logic                detPass,
  output logic                syncPass
);

  localparam int DEPTH  = LAG + WIN;
  localparam int PROD_W = 2 * W + 1;
  localparam int SUM_W  = PROD_W + $clog2(WIN);
  localparam int MAG_W  = 2 * SUM_W;
  localparam int CMP_W  = MAG_W + TH_W + 1;

  // Sample history: tap k holds x(n-1-k) while x(n) is on the ports
  logic signed [W-1:0] histI [DEPTH];
  logic signed [W-1:0] histQ [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) begin
        histI[k] <= '0;
        histQ[k] <= '0;
      end
    end else if (ctl.clearAll) begin
      for (int k = 0; k < DEPTH; k++) begin
        histI[k] <= '0;
        histQ[k] <= '0;
      end
    end else if (ctl.shiftIn) begin
      histI[0] <= sampleI;
      histQ[0] <= sampleQ;
      for (int k = 1; k < DEPTH; k++) begin
        histI[k] <= histI[k-1];
        histQ[k] <= histQ[k-1];
      end
    end
  end

  // Correlation term a*conj(b) and energy |b|^2, full width
  function automatic logic signed [PROD_W-1:0] corrRe(
    input logic signed [W-1:0] ar, input logic signed [W-1:0] ai,
    input logic signed [W-1:0] br, input logic signed [W-1:0] bi);
    return PROD_W'(ar) * PROD_W'(br) + PROD_W'(ai) * PROD_W'(bi);
  endfunction

  function automatic logic signed [PROD_W-1:0] corrIm(
    input logic signed [W-1:0] ar, input logic signed [W-1:0] ai,
    input logic signed [W-1:0] br, input logic signed [W-1:0] bi);
    return PROD_W'(ai) * PROD_W'(br) - PROD_W'(ar) * PROD_W'(bi);
  endfunction

  logic signed [PROD_W-1:0] addRe, addIm, addEn, subRe, subIm, subEn;

  always_comb begin
    // newest term pairs x(n-LAG) with x(n)
    addRe = corrRe(histI[LAG-1], histQ[LAG-1], sampleI, sampleQ);
    addIm = corrIm(histI[LAG-1], histQ[LAG-1], sampleI, sampleQ);
    addEn = corrRe(sampleI, sampleQ, sampleI, sampleQ);
    // leaving term pairs x(n-WIN-LAG) with x(n-WIN)
    subRe = corrRe(histI[DEPTH-1], histQ[DEPTH-1], histI[WIN-1], histQ[WIN-1]);
    subIm = corrIm(histI[DEPTH-1], histQ[DEPTH-1], histI[WIN-1], histQ[WIN-1]);
    subEn = corrRe(histI[WIN-1], histQ[WIN-1], histI[WIN-1], histQ[WIN-1]);
  end

  logic signed [SUM_W-1:0] pRe, pIm, qSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pRe  <= '0;
      pIm  <= '0;
      qSum <= '0;
    end else if (ctl.clearAll) begin
      pRe  <= '0;
      pIm  <= '0;
      qSum <= '0;
    end else if (ctl.shiftIn) begin
      pRe  <= pRe  + SUM_W'(addRe) - SUM_W'(subRe);
      pIm  <= pIm  + SUM_W'(addIm) - SUM_W'(subIm);
      qSum <= qSum + SUM_W'(addEn) - SUM_W'(subEn);
    end
  end

  // Division-free ratio tests on the registered sums
  logic signed [MAG_W-1:0] sqRe, sqIm;
  logic [MAG_W-1:0]        pMag, qSq;
  logic [SUM_W-1:0]        qU;
  logic [CMP_W-1:0]        lhs, rhsDet, rhsSyn;

  always_comb begin
    sqRe   = MAG_W'(pRe) * MAG_W'(pRe);
    sqIm   = MAG_W'(pIm) * MAG_W'(pIm);
    pMag   = $unsigned(sqRe + sqIm);
    qU     = $unsigned(qSum);
    qSq    = MAG_W'(qU) * MAG_W'(qU);
    lhs    = CMP_W'(pMag) << FRAC;
    rhsDet = CMP_W'(thDet) * CMP_W'(qSq);
    rhsSyn = CMP_W'(thSyn) * CMP_W'(qSq);
  end

  assign detPass  = lhs > rhsDet;
  assign syncPass = lhs < rhsSyn;

  // R7
  clear_zeroes_sums_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (pRe == '0 && pIm == '0 && qSum == '0));

  // R8
  idle_holds_sums_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.shiftIn && !ctl.clearAll) |=> ($stable(pRe) && $stable(pIm) && $stable(qSum)));

  // R2
  energy_nonneg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !qSum[SUM_W-1]);

endmodule

// File: rtl/psync_control.sv
module psync_control
  import psync_pkg::*;
#(
  parameter int RUN   = 48,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softClr,
  input  logic             sampleValid,
  input  logic             detPass,
  input  logic             syncPass,
  output dpCtl_t           ctl,
  output logic             frameFound,
  output logic             locked,
  output logic             syncStrobe,
  output logic [CNT_W-1:0] syncIndex
);

  localparam int RUN_W = $clog2(RUN + 1);

  phase_t           phase;
  logic             evalPending;
  logic [RUN_W-1:0] runCnt;
  logic [CNT_W-1:0] sampleCnt;

  assign ctl.clearAll = softClr;
  assign ctl.shiftIn  = sampleValid && !softClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= ST_SEARCH;
      evalPending <= 1'b0;
      runCnt      <= '0;
      sampleCnt   <= '0;
      syncStrobe  <= 1'b0;
      syncIndex   <= '0;
    end else if (softClr) begin
      phase       <= ST_SEARCH;
      evalPending <= 1'b0;
      runCnt      <= '0;
      sampleCnt   <= '0;
      syncStrobe  <= 1'b0;
      syncIndex   <= '0;
    end else begin
      evalPending <= sampleValid;
      syncStrobe  <= 1'b0;
      if (evalPending) begin
        sampleCnt <= sampleCnt + CNT_W'(1);
        unique case (phase)
          ST_SEARCH: begin
            if (!detPass) begin
              runCnt <= '0;
            end else if (runCnt == RUN_W'(RUN - 1)) begin
              runCnt <= '0;
              phase  <= ST_SYNC;
            end else begin
              runCnt <= runCnt + RUN_W'(1);
            end
          end
          ST_SYNC: begin
            if (syncPass) begin
              phase      <= ST_LOCK;
              syncStrobe <= 1'b1;
              syncIndex  <= sampleCnt;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign frameFound = (phase != ST_SEARCH);
  assign locked     = (phase == ST_LOCK);

  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < RUN_W'(RUN));

  // R4
  strobe_on_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |-> (phase == ST_LOCK && $past(phase) == ST_SYNC));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |=> !syncStrobe);

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_LOCK && !softClr) |=> (phase == ST_LOCK));

  // R9
  no_skip_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_SEARCH && !softClr) |=> (phase != ST_LOCK));

  // R5
  index_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !softClr |=> (syncStrobe || $stable(syncIndex)));

endmodule

// File: rtl/preamble_sync.sv
module preamble_sync
  import psync_pkg::*;
#(
  parameter int W     = 12,
  parameter int LAG   = 16,
  parameter int WIN   = 16,
  parameter int RUN   = 48,
  parameter int TH_W  = 16,
  parameter int FRAC  = 8,
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softClr,
  input  logic                sampleValid,
  input  logic signed [W-1:0] sampleI,
  input  logic signed [W-1:0] sampleQ,
  input  logic [TH_W-1:0]     thDet,
  input  logic [TH_W-1:0]     thSyn,
  output logic                frameFound,
  output logic                locked,
  output logic                syncStrobe,
  output logic [CNT_W-1:0]    syncIndex
);

  dpCtl_t ctl;
  logic   detPass;
  logic   syncPass;

  psync_datapath #(
    .W(W), .LAG(LAG), .WIN(WIN), .TH_W(TH_W), .FRAC(FRAC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .sampleI(sampleI), .sampleQ(sampleQ),
    .thDet(thDet), .thSyn(thSyn),
    .detPass(detPass), .syncPass(syncPass)
  );

  psync_control #(
    .RUN(RUN), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .softClr(softClr), .sampleValid(sampleValid),
    .detPass(detPass), .syncPass(syncPass), .ctl(ctl),
    .frameFound(frameFound), .locked(locked),
    .syncStrobe(syncStrobe), .syncIndex(syncIndex)
  );

endmodule

// File: tb/preamble_sync_test.sv
module preamble_sync_test;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 5;
  localparam int LAG   = 4;
  localparam int WIN   = 4;
  localparam int RUN   = 6;
  localparam int TH_W  = 12;
  localparam int FRAC  = 8;
  localparam int CNT_W = 10;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                softClr = 1'b0;
  logic                sampleValid = 1'b0;
  logic signed [W-1:0] sampleI = '0;
  logic signed [W-1:0] sampleQ = '0;
  logic [TH_W-1:0]     thDet = '0;
  logic [TH_W-1:0]     thSyn = '0;
  logic                frameFound, locked, syncStrobe;
  logic [CNT_W-1:0]    syncIndex;

  always #(CLK_PERIOD/2) clk = ~clk;

  preamble_sync #(
    .W(W), .LAG(LAG), .WIN(WIN), .RUN(RUN),
    .TH_W(TH_W), .FRAC(FRAC), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rstN(rstN), .softClr(softClr), .sampleValid(sampleValid),
    .sampleI(sampleI), .sampleQ(sampleQ), .thDet(thDet), .thSyn(thSyn),
    .frameFound(frameFound), .locked(locked),
    .syncStrobe(syncStrobe), .syncIndex(syncIndex)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int hI [512];
  int hQ [512];
  int hN = 0;
  int mPhase = 0;
  int mRun = 0;
  int mCnt = 0;
  int mIdx = 0;
  bit mStrobe = 0;
  logic [15:0] lfsr = 16'hACE1;

  int perI [4] = '{7, -5, 2, -6};
  int perQ [4] = '{3, 6, -8, -4};

  function automatic int xI(int m);
    return (m < 0) ? 0 : hI[m];
  endfunction

  function automatic int xQ(int m);
    return (m < 0) ? 0 : hQ[m];
  endfunction

  // R2 ratio tests computed from scratch over the window
  function automatic bit modelPass(int n, longint th, bit det);
    longint pr = 0;
    longint pi = 0;
    longint q = 0;
    longint lhs;
    longint rhs;
    for (int k = 0; k < WIN; k++) begin
      int m = n - k;
      longint ar = xI(m - LAG);
      longint ai = xQ(m - LAG);
      longint br = xI(m);
      longint bi = xQ(m);
      pr += ar * br + ai * bi;
      pi += ai * br - ar * bi;
      q  += br * br + bi * bi;
    end
    lhs = (pr * pr + pi * pi) * (longint'(1) << FRAC);
    rhs = th * q * q;
    return det ? (lhs > rhs) : (lhs < rhs);
  endfunction

  task automatic check(string ctx, string name, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", ctx, name, act, exp);
    end
  endtask

  task automatic checkAll(string ctx);
    check({ctx, " R3 R9"}, "frameFound", frameFound, (mPhase != 0));
    check({ctx, " R4 R9"}, "locked", locked, (mPhase == 2));
    check({ctx, " R6"}, "syncStrobe", syncStrobe, mStrobe);
    check({ctx, " R5"}, "syncIndex", syncIndex, mIdx);
  endtask

  task automatic modelReset();
    hN = 0; mPhase = 0; mRun = 0; mCnt = 0; mIdx = 0; mStrobe = 0;
  endtask

  task automatic modelStep(int vi, int vq);
    int n = hN;
    hI[n] = vi;
    hQ[n] = vq;
    hN++;
    mStrobe = 0;
    if (mPhase == 0) begin
      if (modelPass(n, longint'(thDet), 1'b1)) begin
        if (mRun == RUN - 1) begin
          mRun = 0;
          mPhase = 1;
        end else begin
          mRun++;
        end
      end else begin
        mRun = 0;
      end
    end else if (mPhase == 1) begin
      if (modelPass(n, longint'(thSyn), 1'b0)) begin
        mPhase = 2;
        mStrobe = 1;
        mIdx = mCnt;
      end
    end
    mCnt = (mCnt + 1) % (1 << CNT_W);
  endtask

  // one sample, outputs checked two edges after acceptance
  task automatic sendSample(int vi, int vq, string ctx);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleI = W'(vi);
    sampleQ = W'(vq);
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    modelStep(vi, vq);
    checkAll(ctx);
  endtask

  task automatic noiseSample(string ctx);
    int vi;
    int vq;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    vi = int'($signed(lfsr[4:0]));
    vq = int'($signed(lfsr[9:5]));
    sendSample(vi, vq, ctx);
  endtask

  // R7 clear, optionally with a sample offered in the same cycle
  task automatic doClear(bit withValid);
    @(negedge clk);
    softClr = 1'b1;
    sampleValid = withValid;
    sampleI = W'(9);
    sampleQ = W'(-3);
    @(posedge clk);
    @(negedge clk);
    softClr = 1'b0;
    sampleValid = 1'b0;
    modelReset();
    @(posedge clk);
    @(negedge clk);
    checkAll("R7");
  endtask

  task automatic runSeq(int nPer, int nNoise, string ctx);
    for (int j = 0; j < nPer; j++) sendSample(perI[j % 4], perQ[j % 4], ctx);
    for (int j = 0; j < nNoise; j++) noiseSample(ctx);
  endtask

  task automatic idleGap(int cyc);
    repeat (cyc) @(posedge clk);
    @(negedge clk);
    mStrobe = 0;
    checkAll("R8");
  endtask

  initial begin
    int detList [6] = '{0, 64, 128, 255, 256, 400};
    int synList [4] = '{16, 128, 255, 300};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R3 R4 main scenario: preamble, then noise, then more traffic while locked (R6)
    thDet = 12'd128;
    thSyn = 12'd64;
    runSeq(16, 12, "R2 main");
    runSeq(8, 4, "R6 locked");

    // R3 run broken by one noise sample, idle gaps mid-search (R8)
    doClear(1'b0);
    runSeq(7, 1, "R3 break");
    idleGap(5);
    runSeq(12, 10, "R3 restart");
    idleGap(7);
    noiseSample("R8 after idle");

    // R7 clear with a sample on the same edge, then fresh history
    doClear(1'b1);
    runSeq(14, 8, "R7 fresh");

    // R2 threshold sweep
    foreach (detList[a]) begin
      foreach (synList[b]) begin
        thDet = TH_W'(detList[a]);
        thSyn = TH_W'(synList[b]);
        doClear(1'b0);
        runSeq(14, 10, "R2 sweep");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule